// File: doc/BRIEF.md
# Receive System-Side Output Formatter

This block sits between the receive front end of a line interface channel and the system side. It takes the raw sliced positive and negative rails, the undecoded NRZ rails, the decoded single-rail NRZ data, the recovered line clock and five status indications. It drives three shared output pins whose meaning is set by a 2-bit format code. Clock recovery, line decoding and alarm generation happen upstream. Their results arrive here as inputs, sampled by the fast system clock `clk`.

A bit period starts at each rising level of `rec_clk`, with `rec_clk` high for the first half of the bit. The format code, the indication selector, the data polarity bit and the clock-edge bit are captured only at that boundary. The NRZ data and the status indications are captured there too. The outputs therefore change format only between bits. Every pin comes from a register clocked by `clk`.

Top module: `rx_sysif_fmt`

## Requirements
- R1: While reset is asserted, and after release until the first bit boundary, `pin_a`, `pin_b` and `pin_c` are all 0.
- R2: Format code 0 (single-rail NRZ): `pin_a` carries the decoded data XOR the polarity bit, held for the whole bit. `pin_b` carries the multifunction indication. `pin_c` carries the recovered clock.
- R3: Format code 1 (dual-rail NRZ): `pin_a` and `pin_b` carry the undecoded positive and negative rails XOR the polarity bit, each held for the whole bit. `pin_c` carries the recovered clock.
- R4: Format code 2 (dual-rail RZ): each rail output is the captured rail ANDed with the recovered clock, then XORed with the polarity bit. The pulse occupies only the first half of the bit. `pin_c` carries the recovered clock.
- R5: Format code 3 (raw sliced): `pin_a` and `pin_b` follow `sl_pos` and `sl_neg` XOR the polarity bit, without any capture at the bit boundary. `pin_c` carries the multifunction indication.
- R6: The 3-bit selector picks the multifunction indication. Its codes are: 0 PRBS/ARB, 1 AIS, 2 excess zeros, 3 bipolar violation, 4 excess zeros OR bipolar violation, 5 loss of signal, 6 recovered clock, 7 `sl_pos` XOR `sl_neg`. The indication is active high, and the polarity bit never changes it.
- R7: Indications 0 to 5 are sampled at the bit boundary. A change of a status input later in the bit does not reach the multifunction output before the next boundary.
- R8: A change of the format code, the selector, the polarity bit or the clock-edge bit in the middle of a bit leaves the outputs in the old configuration for the rest of that bit. The new configuration applies from the next boundary.
- R9: Wherever a pin carries the recovered clock, the clock-edge bit inverts it. The polarity bit never affects the clock pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_clk | input | 1 | Recovered line clock level, high in the first half of a bit |
| sl_pos | input | 1 | Raw sliced positive rail |
| sl_neg | input | 1 | Raw sliced negative rail |
| nrz_pos | input | 1 | Undecoded positive rail, NRZ |
| nrz_neg | input | 1 | Undecoded negative rail, NRZ |
| dec_data | input | 1 | Decoded single-rail NRZ data |
| st_prbs | input | 1 | PRBS/ARB pattern status |
| st_ais | input | 1 | Alarm indication signal status |
| st_exz | input | 1 | Excess zeros status |
| st_bpv | input | 1 | Bipolar violation status |
| st_los | input | 1 | Loss of signal status |
| cfg_mode | input | 2 | Format code 0..3 (see R2 to R5) |
| cfg_mfsel | input | 3 | Multifunction indication selector (see R6) |
| cfg_inv | input | 1 | Data polarity: 1 inverts the data pins |
| cfg_edge | input | 1 | Clock-edge select: 1 inverts the clock pin |
| pin_a | output | 1 | Shared pin: data or positive rail |
| pin_b | output | 1 | Shared pin: indication or negative rail |
| pin_c | output | 1 | Shared pin: recovered clock or indication |

## Verification
The bench sweeps every combination of format code, polarity, clock edge and selector. It plays three bits per combination, with data and status drawn from a hash of the bit index. It samples each pin in both halves of every bit. The two halves separate the NRZ, RZ and sliced shapes, and the clock polarity. Within each bit the bench toggles the data and status inputs after the first-half sample. A design that passes inputs through instead of capturing them at the boundary then disagrees in the second half. Further bits change the configuration in the middle of a bit, which separates boundary-aligned switching from immediate switching.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      RXF_SNRZ   = 2'd0,
      RXF_DNRZ   = 2'd1,
      RXF_DRZ    = 2'd2,
      RXF_SLICED = 2'd3
   } rxf_mode_e;

   localparam int RXF_SEL_W   = 3;
   localparam int RXF_N_STAT  = 5;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_PRBS = 3'd0;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_AIS  = 3'd1;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_EXZ  = 3'd2;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_BPV  = 3'd3;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_EORB = 3'd4;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_LOS  = 3'd5;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_CLK  = 3'd6;
   localparam logic [RXF_SEL_W-1:0] RXF_SEL_XOR  = 3'd7;

   typedef struct packed {
      rxf_mode_e               mode;
      logic [RXF_SEL_W-1:0]    sel;
      logic                    inv;
      logic                    edge_inv;
   } rxf_cfg_t;

   localparam rxf_cfg_t RXF_CFG_RST = '{mode: RXF_SNRZ, sel: '0, inv: 1'b0, edge_inv: 1'b0};

endpackage

// File: rtl/rxf_bit_timer.sv
module rxf_bit_timer (
   input  logic clk,
   input  logic rst_n,
   input  logic rec_clk,
   output logic rc_q,
   output logic bnd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rc_q <= 1'b0;
      else        rc_q <= rec_clk;
   end

   // A bit starts where the sampled recovered clock rises.
   assign bnd = rec_clk & ~rc_q;
endmodule

// File: rtl/rxf_cfg_latch.sv
module rxf_cfg_latch
   import rxf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bnd,
   input  rxf_cfg_t cfg_nxt,
   output rxf_cfg_t cfg_act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_act <= RXF_CFG_RST;
      else if (bnd) cfg_act <= cfg_nxt;
   end
endmodule

// File: rtl/rxf_rail_hold.sv
module rxf_rail_hold #(
   parameter int N_RAIL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bnd,
   input  logic              dec_in,
   input  logic [N_RAIL-1:0] rail_in,
   output logic              dec_q,
   output logic [N_RAIL-1:0] rail_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_q  <= 1'b0;
         rail_q <= '0;
      end else if (bnd) begin
         dec_q  <= dec_in;
         rail_q <= rail_in;
      end
   end
endmodule

// File: rtl/rxf_ind_sel.sv
module rxf_ind_sel
   import rxf_pkg::*;
#(
   parameter int SEL_W  = RXF_SEL_W,
   parameter int N_STAT = RXF_N_STAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bnd,
   input  logic [SEL_W-1:0]  sel_nxt,
   input  logic [SEL_W-1:0]  sel_act,
   input  logic [N_STAT-1:0] stat_in,   // {los, bpv, exz, ais, prbs}
   input  logic              rc_q,
   input  logic              sl_x,
   output logic              mf_hold,
   output logic              mf_lvl
);
   localparam int N_IND = 1 << SEL_W;

   logic [N_IND-1:0] ind_vec;

   always_comb begin
      ind_vec = '0;
      ind_vec[RXF_SEL_PRBS] = stat_in[0];
      ind_vec[RXF_SEL_AIS]  = stat_in[1];
      ind_vec[RXF_SEL_EXZ]  = stat_in[2];
      ind_vec[RXF_SEL_BPV]  = stat_in[3];
      ind_vec[RXF_SEL_EORB] = stat_in[2] | stat_in[3];
      ind_vec[RXF_SEL_LOS]  = stat_in[4];
      ind_vec[RXF_SEL_CLK]  = rc_q;
      ind_vec[RXF_SEL_XOR]  = sl_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mf_hold <= 1'b0;
      else if (bnd) mf_hold <= ind_vec[sel_nxt];
   end

   // The status indications are held per bit; the clock and the XOR of the
   // sliced rails are continuous waveforms.
   always_comb begin
      unique case (sel_act)
         RXF_SEL_CLK: mf_lvl = rc_q;
         RXF_SEL_XOR: mf_lvl = sl_x;
         default:     mf_lvl = mf_hold;
      endcase
   end
endmodule

// File: rtl/rx_sysif_fmt.sv
module rx_sysif_fmt
   import rxf_pkg::*;
#(
   parameter int MODE_W = 2,
   parameter int SEL_W  = RXF_SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_clk,
   input  logic              sl_pos,
   input  logic              sl_neg,
   input  logic              nrz_pos,
   input  logic              nrz_neg,
   input  logic              dec_data,
   input  logic              st_prbs,
   input  logic              st_ais,
   input  logic              st_exz,
   input  logic              st_bpv,
   input  logic              st_los,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic [SEL_W-1:0]  cfg_mfsel,
   input  logic              cfg_inv,
   input  logic              cfg_edge,
   output logic              pin_a,
   output logic              pin_b,
   output logic              pin_c
);
   localparam int N_RAIL = 2;
   localparam int N_IND  = 1 << SEL_W;

   generate
      if (MODE_W != 2) begin : g_bad_mode
         $error("rx_sysif_fmt: MODE_W must be 2");
      end
      if (SEL_W != RXF_SEL_W || N_IND != 8) begin : g_bad_sel
         $error("rx_sysif_fmt: selector must address eight indications");
      end
   endgenerate

   logic              rc_q, bnd;
   rxf_cfg_t          cfg_nxt, cfg_act;
   logic [1:0]        mode_act;
   logic [SEL_W-1:0]  sel_act;
   logic              inv_act, edge_act;
   logic              dec_q;
   logic [N_RAIL-1:0] rail_in, rail_q, sl_in;
   logic [N_RAIL-1:0] rail_nrz, rail_rz, rail_raw;
   logic              mf_hold, mf_lvl;
   logic              clk_pin;
   logic              a_d, b_d, c_d;

   rxf_bit_timer u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rec_clk (rec_clk),
      .rc_q    (rc_q),
      .bnd     (bnd)
   );

   assign cfg_nxt = '{mode: rxf_mode_e'(cfg_mode), sel: cfg_mfsel,
                      inv: cfg_inv, edge_inv: cfg_edge};

   rxf_cfg_latch u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .bnd     (bnd),
      .cfg_nxt (cfg_nxt),
      .cfg_act (cfg_act)
   );

   assign mode_act = cfg_act.mode;
   assign sel_act  = cfg_act.sel;
   assign inv_act  = cfg_act.inv;
   assign edge_act = cfg_act.edge_inv;

   assign rail_in = {nrz_neg, nrz_pos};
   assign sl_in   = {sl_neg, sl_pos};

   rxf_rail_hold #(.N_RAIL(N_RAIL)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .bnd     (bnd),
      .dec_in  (dec_data),
      .rail_in (rail_in),
      .dec_q   (dec_q),
      .rail_q  (rail_q)
   );

   rxf_ind_sel #(.SEL_W(SEL_W), .N_STAT(RXF_N_STAT)) u_ind (
      .clk     (clk),
      .rst_n   (rst_n),
      .bnd     (bnd),
      .sel_nxt (cfg_mfsel),
      .sel_act (sel_act),
      .stat_in ({st_los, st_bpv, st_exz, st_ais, st_prbs}),
      .rc_q    (rc_q),
      .sl_x    (sl_pos ^ sl_neg),
      .mf_hold (mf_hold),
      .mf_lvl  (mf_lvl)
   );

   // Per-rail shaping for the three dual-rail formats.
   generate
      for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
         assign rail_nrz[r] = rail_q[r] ^ inv_act;
         assign rail_rz[r]  = (rail_q[r] & rc_q) ^ inv_act;
         assign rail_raw[r] = sl_in[r] ^ inv_act;
      end
   endgenerate

   assign clk_pin = rc_q ^ edge_act;

   always_comb begin
      unique case (rxf_mode_e'(mode_act))
         RXF_SNRZ:   begin a_d = dec_q ^ inv_act; b_d = mf_lvl;      c_d = clk_pin; end
         RXF_DNRZ:   begin a_d = rail_nrz[0];     b_d = rail_nrz[1]; c_d = clk_pin; end
         RXF_DRZ:    begin a_d = rail_rz[0];      b_d = rail_rz[1];  c_d = clk_pin; end
         RXF_SLICED: begin a_d = rail_raw[0];     b_d = rail_raw[1]; c_d = mf_lvl;  end
         default:    begin a_d = 1'b0;            b_d = 1'b0;        c_d = 1'b0;    end
      endcase
   end

   // Registered pins: no combinational path from a mux select to a pin.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_a <= 1'b0;
         pin_b <= 1'b0;
         pin_c <= 1'b0;
      end else begin
         pin_a <= a_d;
         pin_b <= b_d;
         pin_c <= c_d;
      end
   end
endmodule

// File: rtl/rx_sysif_fmt_chk.sv
module rx_sysif_fmt_chk #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bnd,
   input logic             rc_q,
   input logic [1:0]       mode_act,
   input logic [SEL_W-1:0] sel_act,
   input logic             inv_act,
   input logic             mf_hold,
   input logic             pin_a,
   input logic             pin_b
);
   // R8: configuration moves only at a bit boundary
   a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> ($stable(mode_act) && $stable(sel_act) && $stable(inv_act)));

   // R4: RZ rails are idle in the second half of a bit
   a_r4_rz_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == 2'd2 && !inv_act && !rc_q && !bnd) |=> (!pin_a && !pin_b));

   // R7: held indication does not move between boundaries
   a_r7_mf_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(mf_hold));

   // R2: single-rail data pin is flat within a bit
   a_r2_nrz_flat: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == 2'd0 && !bnd && !$past(bnd)) |=> $stable(pin_a));

   // R3: dual-rail NRZ pins are flat within a bit
   a_r3_nrz_flat: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_act == 2'd1 && !bnd && !$past(bnd)) |=> ($stable(pin_a) && $stable(pin_b)));
endmodule

bind rx_sysif_fmt rx_sysif_fmt_chk #(.SEL_W(SEL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bnd      (bnd),
   .rc_q     (rc_q),
   .mode_act (mode_act),
   .sel_act  (sel_act),
   .inv_act  (inv_act),
   .mf_hold  (mf_hold),
   .pin_a    (pin_a),
   .pin_b    (pin_b)
);

// File: tb/tb_rx_sysif_fmt.sv
module tb_rx_sysif_fmt;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rec_clk = 1'b0, sl_pos = 1'b0, sl_neg = 1'b0;
   logic nrz_pos = 1'b0, nrz_neg = 1'b0, dec_data = 1'b0;
   logic st_prbs = 1'b0, st_ais = 1'b0, st_exz = 1'b0, st_bpv = 1'b0, st_los = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic [2:0] cfg_mfsel = 3'd0;
   logic cfg_inv = 1'b0, cfg_edge = 1'b0;
   logic pin_a, pin_b, pin_c;

   int vecs = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rx_sysif_fmt dut (
      .clk(clk), .rst_n(rst_n), .rec_clk(rec_clk),
      .sl_pos(sl_pos), .sl_neg(sl_neg), .nrz_pos(nrz_pos), .nrz_neg(nrz_neg),
      .dec_data(dec_data), .st_prbs(st_prbs), .st_ais(st_ais), .st_exz(st_exz),
      .st_bpv(st_bpv), .st_los(st_los), .cfg_mode(cfg_mode), .cfg_mfsel(cfg_mfsel),
      .cfg_inv(cfg_inv), .cfg_edge(cfg_edge),
      .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      vecs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   // Multifunction level from the selector code table (R6).
   function automatic logic mf_exp(input logic [2:0] s, input logic [4:0] st,
                                   input logic clkl, input logic x);
      case (s)
         3'd0: return st[0];
         3'd1: return st[1];
         3'd2: return st[2];
         3'd3: return st[3];
         3'd4: return st[2] | st[3];
         3'd5: return st[4];
         3'd6: return clkl;
         default: return x;
      endcase
   endfunction

   // Check all pins for one half of a bit, given the configuration in force.
   task automatic chk_half(input logic [1:0] m, input logic [2:0] s, input logic inv,
                           input logic edg, input logic hi, input logic d,
                           input logic p, input logic n, input logic sp, input logic sn,
                           input logic [4:0] st, input string tag);
      logic ea, eb, ec, mf, spv, snv;
      string rq;
      spv = hi ? sp : 1'b0;
      snv = hi ? sn : 1'b0;
      mf  = mf_exp(s, st, hi, spv ^ snv);
      case (m)
         2'd0: begin ea = d ^ inv;          eb = mf;                ec = hi ^ edg; rq = "R2"; end
         2'd1: begin ea = p ^ inv;          eb = n ^ inv;           ec = hi ^ edg; rq = "R3"; end
         2'd2: begin ea = (p & hi) ^ inv;   eb = (n & hi) ^ inv;    ec = hi ^ edg; rq = "R4"; end
         default: begin ea = spv ^ inv;     eb = snv ^ inv;         ec = mf;       rq = "R5"; end
      endcase
      if (tag.len() != 0) rq = tag;
      chk(rq, hi ? "pin_a hi" : "pin_a lo", pin_a, ea);
      chk((m == 2'd0 && tag.len() == 0) ? (hi ? "R6" : "R7") : rq,
          hi ? "pin_b hi" : "pin_b lo", pin_b, eb);
      chk((m == 2'd3 && tag.len() == 0) ? (hi ? "R6" : "R7") :
          (tag.len() == 0 ? "R9" : rq), hi ? "pin_c hi" : "pin_c lo", pin_c, ec);
   endtask

   // One bit of 8 clocks. Inputs flip after the first-half sample; when chg
   // is set the configuration also changes there (R8).
   task automatic run_bit(input int k, input bit chg, input logic [1:0] nm,
                          input logic [2:0] ns, input logic ni, input logic ne);
      int unsigned h;
      logic [1:0] m;
      logic [2:0] s;
      logic inv, edg, d, p, n, sp, sn;
      logic [4:0] st;
      h = (k + 1) * 32'd2246822519;
      h = h ^ (h >> 13);
      d = h[3]; p = h[5]; n = h[8]; sp = h[11]; sn = h[14];
      st = h[20:16];
      m = cfg_mode; s = cfg_mfsel; inv = cfg_inv; edg = cfg_edge;
      rec_clk = 1'b1; dec_data = d; nrz_pos = p; nrz_neg = n;
      sl_pos = sp; sl_neg = sn;
      {st_los, st_bpv, st_exz, st_ais, st_prbs} = st;
      repeat (3) @(negedge clk);
      chk_half(m, s, inv, edg, 1'b1, d, p, n, sp, sn, st, "");
      dec_data = ~d; nrz_pos = ~p; nrz_neg = ~n;
      {st_los, st_bpv, st_exz, st_ais, st_prbs} = ~st;   // R7: late change
      if (chg) begin
         cfg_mode = nm; cfg_mfsel = ns; cfg_inv = ni; cfg_edge = ne;
      end
      @(negedge clk);
      rec_clk = 1'b0; sl_pos = 1'b0; sl_neg = 1'b0;
      repeat (3) @(negedge clk);
      chk_half(m, s, inv, edg, 1'b0, d, p, n, sp, sn, st, chg ? "R8" : "");
      @(negedge clk);
   endtask

   initial begin
      int k;
      k = 0;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "pin_a rst", pin_a, 1'b0);
      chk("R1", "pin_b rst", pin_b, 1'b0);
      chk("R1", "pin_c rst", pin_c, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "pin_a idle", pin_a, 1'b0);
      chk("R1", "pin_b idle", pin_b, 1'b0);
      chk("R1", "pin_c idle", pin_c, 1'b0);

      // Full sweep of format, polarity, edge and selector.
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 2; i++)
            for (int e = 0; e < 2; e++)
               for (int s = 0; s < 8; s++) begin
                  cfg_mode = 2'(m); cfg_inv = 1'(i); cfg_edge = 1'(e); cfg_mfsel = 3'(s);
                  for (int b = 0; b < 3; b++) begin
                     run_bit(k, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
                     k++;
                  end
               end

      // R8: mid-bit configuration changes, then a bit in the new setup.
      for (int t = 0; t < 6; t++) begin
         cfg_mode = 2'(t % 4); cfg_mfsel = 3'(t); cfg_inv = 1'(t % 2); cfg_edge = 1'(t / 3);
         run_bit(k, 1'b1, 2'(3 - (t % 4)), 3'(7 - t), 1'(~t[0]), 1'(~t[1]));
         k++;
         run_bit(k, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0);
         k++;
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end
endmodule